// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Operand Register

This block multiplies two 16-bit operands into a 32-bit product in one clock and adds products into a 32-bit accumulator. One operand is parked in a 16-bit holding register (`tmp_q`). It is written from `opnd_a` when `ld_tmp` is high. The other operand arrives on `opnd_b` in the cycle the multiply is issued. The result is registered in a 32-bit product register, and `sgn_mode` selects a two's-complement or an unsigned product.

A MAC strobe does two things in the same clock. It adds the product register's current value into the accumulator, and it registers the new product of the holding register and `opnd_b`. This lets a stream of MAC strobes, one per cycle, add up the product formed in each earlier cycle. The sum wraps modulo 2^32. A sticky flag records any signed overflow, and a clear input zeroes both the accumulator and the flag.

Top module: `mac_unit`

## Requirements
- R1: After reset the holding register, product register and accumulator read zero and `acc_ovf` is low.
- R2: The holding register takes `opnd_a` at a clock edge where `ld_tmp` is high and keeps its value at every other edge; a multiply issued in the same cycle as a load uses the old value.
- R3: At an edge where `mul_go` or `mac_go` is high, `prod` becomes holding register × `opnd_b`: a two's-complement product when `sgn_mode`=1, an unsigned product when `sgn_mode`=0 (0xFFFF×0xFFFF gives 0xFFFE0001 unsigned and 0x00000001 signed).
- R4: The signed product of 0x8000 by 0x8000 is 0x40000000, and 0x8000 by 0x7FFF is 0xC0008000.
- R5: `prod` keeps its value at every edge where neither `mul_go` nor `mac_go` is high.
- R6: At an edge where `mac_go` is high and `acc_clr` is low, `acc` becomes the old `acc` plus the old `prod`, while `prod` takes the new product. MAC strobes may be issued on consecutive cycles.
- R7: The accumulator addition wraps modulo 2^32. `acc_ovf` goes high when two addends with the same sign give a sum with the other sign, and it stays high until a clear.
- R8: At an edge where `acc_clr` is high, `acc` becomes zero and `acc_ovf` low even if `mac_go` is high; the product register still updates on that strobe.
- R9: `acc` keeps its value at every edge where `mac_go` and `acc_clr` are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_a | input | 16 | Value written into the holding register |
| opnd_b | input | 16 | Second multiplier operand, used in the cycle it is presented |
| ld_tmp | input | 1 | Write `opnd_a` into the holding register |
| mul_go | input | 1 | Register a new product |
| mac_go | input | 1 | Add the product into the accumulator and register a new product |
| sgn_mode | input | 1 | 1 = signed product, 0 = unsigned product |
| acc_clr | input | 1 | Zero the accumulator and the overflow flag |
| prod | output | 32 | Product register |
| acc | output | 32 | Accumulator |
| acc_ovf | output | 1 | Sticky signed-overflow flag |

## Verification
The assertions check, on every cycle, the rules about holding values and the accumulator's update. The holding register, product and accumulator keep their values when not strobed. A MAC adds the previous product. A clear wins over a MAC, and the overflow flag stays set once raised. The numeric value of each product needs the bench's scenarios. These cover signed and unsigned corner operands, the most-negative squared case, and a MAC stream whose running sum crosses the signed limit and wraps.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int OPW = 16;
    localparam int PRW = 2 * OPW;
    typedef logic [OPW-1:0] opnd_t;
    typedef logic [PRW-1:0] prod_t;
endpackage

// File: rtl/mac_tmp_reg.sv
module mac_tmp_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           sgn,
    output logic [2*W-1:0] p
);
    localparam int XW = W + 1;
    localparam int FW = 2 * XW;
    logic signed [XW-1:0] ax, bx;
    logic signed [FW-1:0] full;
    always_comb begin
        ax   = $signed({sgn & a[W-1], a});
        bx   = $signed({sgn & b[W-1], b});
        full = ax * bx;
        p    = full[2*W-1:0];
    end
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add,
    input  logic [W-1:0] addend,
    output logic [W-1:0] sum_q,
    output logic         ovf_q
);
    logic [W-1:0] sum_n;
    logic         ovf_now;
    always_comb begin
        sum_n   = sum_q + addend;
        ovf_now = (sum_q[W-1] == addend[W-1]) && (sum_n[W-1] != sum_q[W-1]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            ovf_q <= 1'b0;
        end else if (clr) begin
            sum_q <= '0;
            ovf_q <= 1'b0;
        end else if (add) begin
            sum_q <= sum_n;
            ovf_q <= ovf_q | ovf_now;
        end
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] opnd_a,
    input  logic [15:0] opnd_b,
    input  logic        ld_tmp,
    input  logic        mul_go,
    input  logic        mac_go,
    input  logic        sgn_mode,
    input  logic        acc_clr,
    output logic [31:0] prod,
    output logic [31:0] acc,
    output logic        acc_ovf
);
    opnd_t tmp_q;
    prod_t prod_n;
    prod_t prod_q;

    mac_tmp_reg #(.W(OPW)) u_tmp (
        .clk(clk), .rst_n(rst_n), .ld(ld_tmp), .d(opnd_a), .q(tmp_q)
    );

    mac_mult #(.W(OPW)) u_mul (
        .a(tmp_q), .b(opnd_b), .sgn(sgn_mode), .p(prod_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                prod_q <= '0;
        else if (mul_go || mac_go) prod_q <= prod_n;
    end

    mac_accum #(.W(PRW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(mac_go),
        .addend(prod_q), .sum_q(acc), .ovf_q(acc_ovf)
    );

    assign prod = prod_q;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ld_tmp,
    input logic        mul_go,
    input logic        mac_go,
    input logic        acc_clr,
    input logic [15:0] opnd_a,
    input logic [15:0] tmp_q,
    input logic [31:0] prod,
    input logic [31:0] acc,
    input logic        acc_ovf
);
    AST_TMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n) ld_tmp |=> tmp_q == $past(opnd_a)); // R2
    AST_TMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ld_tmp |=> $stable(tmp_q)); // R2
    AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(mul_go || mac_go) |=> $stable(prod)); // R5
    AST_MAC_ADD: assert property (@(posedge clk) disable iff (!rst_n) (mac_go && !acc_clr) |=> acc == $past(acc) + $past(prod)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (acc_ovf && !acc_clr) |=> acc_ovf); // R7
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n) acc_clr |=> (acc == 32'd0) && !acc_ovf); // R8
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!mac_go && !acc_clr) |=> $stable(acc) && $stable(acc_ovf)); // R9
endmodule

bind mac_unit mac_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ld_tmp(ld_tmp), .mul_go(mul_go), .mac_go(mac_go),
    .acc_clr(acc_clr), .opnd_a(opnd_a), .tmp_q(tmp_q), .prod(prod), .acc(acc),
    .acc_ovf(acc_ovf)
);

// File: tb/sim_mac_unit.sv
`timescale 1ns/1ps
module sim_mac_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic        ld_tmp = 1'b0, mul_go = 1'b0, mac_go = 1'b0, sgn_mode = 1'b0, acc_clr = 1'b0;
    logic [31:0] prod, acc;
    logic        acc_ovf;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mac_unit u0 (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b), .ld_tmp(ld_tmp),
        .mul_go(mul_go), .mac_go(mac_go), .sgn_mode(sgn_mode), .acc_clr(acc_clr),
        .prod(prod), .acc(acc), .acc_ovf(acc_ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        ld_tmp = 0; mul_go = 0; mac_go = 0; acc_clr = 0;
    endtask

    task automatic load(input logic [15:0] v);
        opnd_a = v; ld_tmp = 1; step();
    endtask

    task automatic mul(input logic [15:0] b, input logic s);
        opnd_b = b; sgn_mode = s; mul_go = 1; step();
    endtask

    task automatic t_reset();
        chk("R1 prod", prod, 0);
        chk("R1 acc", acc, 0);
        chk("R1 ovf", {31'd0, acc_ovf}, 0);
    endtask

    task automatic t_products();
        load(16'd3);
        mul(16'hFFFB, 1); chk("R3 signed 3*-5", prod, 32'hFFFFFFF1);
        mul(16'hFFFB, 0); chk("R3 unsigned 3*0xFFFB", prod, 32'h0002FFF1);
        load(16'hFFFF);
        mul(16'hFFFF, 0); chk("R3 unsigned max", prod, 32'hFFFE0001);
        mul(16'hFFFF, 1); chk("R3 signed -1*-1", prod, 32'h00000001);
        load(16'h8000);
        mul(16'h8000, 1); chk("R4 min*min", prod, 32'h40000000);
        mul(16'h7FFF, 1); chk("R4 min*max", prod, 32'hC0008000);
    endtask

    task automatic t_hold();
        opnd_a = 16'd9; opnd_b = 16'd77;
        step(); step();
        chk("R5 prod held", prod, 32'hC0008000);
        chk("R9 acc held", acc, 0);
        // same-cycle load and multiply uses old value (0x8000)
        opnd_a = 16'd2; ld_tmp = 1; opnd_b = 16'd1; sgn_mode = 0; mul_go = 1; step();
        chk("R2 old value used", prod, 32'h00008000);
        mul(16'd1, 0); chk("R2 new value loaded", prod, 32'd2);
        opnd_a = 16'd50; step();
        mul(16'd1, 0); chk("R2 no load without strobe", prod, 32'd2);
    endtask

    task automatic t_mac();
        acc_clr = 1; step();
        mul(16'd10, 1); chk("R3 2*10", prod, 32'd20);
        opnd_b = 16'd7; mac_go = 1; step();
        chk("R6 acc 1st", acc, 32'd20); chk("R6 prod 1st", prod, 32'd14);
        opnd_b = 16'd1; mac_go = 1; step();
        chk("R6 acc 2nd", acc, 32'd34); chk("R6 prod 2nd", prod, 32'd2);
        opnd_b = 16'd0; mac_go = 1; step();
        chk("R6 acc 3rd", acc, 32'd36);
        step(); chk("R9 acc idle", acc, 32'd36);
    endtask

    task automatic t_ovf();
        acc_clr = 1; step();
        load(16'h7FFF);
        mul(16'h7FFF, 1); chk("R3 max*max", prod, 32'h3FFF0001);
        mac_go = 1; step(); chk("R7 sum1", acc, 32'h3FFF0001);
        mac_go = 1; step(); chk("R7 sum2", acc, 32'h7FFE0002);
        chk("R7 no ovf yet", {31'd0, acc_ovf}, 0);
        opnd_b = 16'd0; mac_go = 1; step();
        chk("R7 wrap", acc, 32'hBFFD0003);
        chk("R7 ovf set", {31'd0, acc_ovf}, 1);
        mac_go = 1; step();
        chk("R7 ovf sticky", {31'd0, acc_ovf}, 1);
        chk("R7 acc +0", acc, 32'hBFFD0003);
    endtask

    task automatic t_clr();
        opnd_b = 16'd2; mac_go = 1; acc_clr = 1; step();
        chk("R8 acc cleared", acc, 0);
        chk("R8 ovf cleared", {31'd0, acc_ovf}, 0);
        chk("R8 prod updated", prod, 32'h0000FFFE);
    endtask

    initial begin
        #(CLK_P*2 + 1);
        t_reset();
        rst_n = 1;
        step();
        t_products();
        t_hold();
        t_mac();
        t_ovf();
        t_clr();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule